// File: doc/BRIEF.md
# Multi-Lane Serial Transfer Engine

This block is the master side of a half-duplex serial link that moves bytes over one, two or four data lanes. It makes the serial clock and an active-low select itself. One transaction has an optional write phase followed by an optional read phase. The lanes are driven during the write phase. During the read phase they are released and sampled. When a transaction has both phases, one idle clock separates them so that the lanes can change direction.

The bytes to send arrive over a valid/ready stream. The engine asks for each byte in turn and holds the serial clock low until that byte arrives. Received bytes leave on a valid strobe with no back-pressure: the consumer must take each one in the cycle it appears. The lane count, the number of bytes to write and the number of bytes to read are captured when a transaction starts. The bidirectional pads are modelled as separate in, out and enable vectors so that the pad ring can combine them.

Top module: `qspi_lane_engine`

## Requirements
- R1: After reset, and between transactions, `cs_n` is 1 and `sclk` is 0. `io_oe` is 0, and `busy`, `tx_ready` and `rx_valid` are 0.
- R2: Every output change on the lanes happens while `sclk` is low. `io_in` is sampled at the rising edge of `sclk`.
- R3: With `lane_sel`=2 (four lanes), `io_out[3:0]` carries byte bits 7..4 on the first clock and bits 3..0 on the second, with io3 holding the highest bit of each group. Received lanes pack into bytes the same way.
- R4: With `lane_sel`=1 (two lanes), io1 carries the odd bits and io0 the even bits. The pairs go out from (7,6) down to (1,0). Reads pack the same way, and `io_in[3:2]` is ignored.
- R5: With `lane_sel`=0 or the reserved code 3 (one lane), data goes out on io0 with the MSB first and comes in on io1. Reads ignore `io_in` bits 0, 2 and 3.
- R6: A byte takes 8, 4 or 2 rising `sclk` edges for one, two or four lanes.
- R7: During write clocks `io_oe` is 4'b0001, 4'b0011 or 4'b1111 for one, two or four lanes. During read clocks it is 0.
- R8: If a transaction has both a write and a read phase, exactly one `sclk` period with `io_oe`=0 and no sampling lies between them. A read-only transaction has no such period.
- R9: `tx_ready` is high once for each byte to send. The byte is taken on a cycle where `tx_valid` and `tx_ready` are both high. While the engine waits for that byte, `sclk` stays low.
- R10: `rx_valid` pulses for one cycle for each received byte, with the packed byte on `rx_data`.
- R11: Exactly `wr_len` bytes are sent and `rd_len` bytes are received. A `start` with both lengths zero is ignored. A `start` while `busy` is high is ignored.
- R12: `cs_n` is low from the cycle after an accepted `start` until the cycle after the last falling `sclk` edge, and it covers every clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin a transaction (sampled when idle) |
| lane_sel | input | 2 | 0/3 one lane, 1 two lanes, 2 four lanes |
| wr_len | input | LEN_W | Bytes in the write phase |
| rd_len | input | LEN_W | Bytes in the read phase |
| busy | output | 1 | Transaction in progress |
| tx_data | input | DATA_W | Byte to send |
| tx_valid | input | 1 | `tx_data` is valid |
| tx_ready | output | 1 | Engine takes a byte this cycle if valid |
| rx_data | output | DATA_W | Received byte, valid with `rx_valid` |
| rx_valid | output | 1 | One-cycle strobe per received byte |
| cs_n | output | 1 | Active-low select |
| sclk | output | 1 | Serial clock, idles low |
| io_in | input | 4 | Lane input values |
| io_out | output | 4 | Lane output values (0 when not enabled) |
| io_oe | output | 4 | Per-lane output enable |

## Verification
Each `sclk` period is two system clocks. The rise comes on the second edge after `start` for a read-only transaction, and on the second edge after the first byte is accepted for a write. A write byte takes 2·beats+1 cycles when `tx_valid` is already waiting, and a read byte takes 2·beats. `rx_valid` appears in the cycle after the edge that samples the last group. The bench samples every output on the falling system clock. It counts rising `sclk` edges to find the expected lane group, presents read data only while `sclk` is low, and checks the accepted-byte, received-byte and edge totals once `busy` drops.

// File: rtl/qsl_pkg.sv
package qsl_pkg;
  typedef enum logic [1:0] {
    LW_ONE  = 2'd0,
    LW_TWO  = 2'd1,
    LW_FOUR = 2'd2
  } lane_w_e;

  typedef enum logic [3:0] {
    ST_IDLE, ST_LOAD, ST_WLO, ST_WHI, ST_TLO, ST_THI, ST_RLO, ST_RHI, ST_END
  } st_e;

  localparam int NLANE = 4;
endpackage

// File: rtl/qsl_lane_map.sv
module qsl_lane_map
  import qsl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  lane_w_e                lw,
  input  logic                   drive,
  input  logic [DATA_W-1:0]      sh,
  input  logic [NLANE-1:0]       io_in,
  output logic [NLANE-1:0]       io_out,
  output logic [NLANE-1:0]       io_oe,
  output logic [NLANE-1:0]       fill
);
  logic [NLANE-1:0] grp, mask;

  always_comb begin
    case (lw)
      LW_FOUR: begin
        grp  = sh[DATA_W-1 -: 4];
        mask = 4'b1111;
        fill = io_in;
      end
      LW_TWO: begin
        grp  = {2'b00, sh[DATA_W-1 -: 2]};
        mask = 4'b0011;
        fill = {2'b00, io_in[1:0]};
      end
      default: begin
        grp  = {3'b000, sh[DATA_W-1]};
        mask = 4'b0001;
        fill = {3'b000, io_in[1]};
      end
    endcase
  end

  assign io_oe = drive ? mask : '0;

  for (genvar i = 0; i < NLANE; i++) begin : g_lane
    assign io_out[i] = grp[i] & io_oe[i];
  end

  // R7: enables always form a contiguous group from lane 0
  always_comb begin
    assert_lane_mask_R7: assert (io_oe == 4'b0000 || io_oe == 4'b0001 ||
                                 io_oe == 4'b0011 || io_oe == 4'b1111);
  end
endmodule

// File: rtl/qsl_shifter.sv
module qsl_shifter
  import qsl_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load,
  input  logic [DATA_W-1:0]  load_val,
  input  logic               shift,
  input  lane_w_e            lw,
  input  logic [NLANE-1:0]   fill,
  output logic [DATA_W-1:0]  sh
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh <= '0;
    end else if (load) begin
      sh <= load_val;
    end else if (shift) begin
      case (lw)
        LW_FOUR: sh <= {sh[DATA_W-5:0], fill[3:0]};
        LW_TWO:  sh <= {sh[DATA_W-3:0], fill[1:0]};
        default: sh <= {sh[DATA_W-2:0], fill[0]};
      endcase
    end
  end

  // R10: a byte is never loaded while bits are still moving
  assert_load_shift_excl_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));
endmodule

// File: rtl/qspi_lane_engine.sv
module qspi_lane_engine
  import qsl_pkg::*;
#(
  parameter int DATA_W = 8,
  parameter int LEN_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [1:0]        lane_sel,
  input  logic [LEN_W-1:0]  wr_len,
  input  logic [LEN_W-1:0]  rd_len,
  output logic              busy,
  input  logic [DATA_W-1:0] tx_data,
  input  logic              tx_valid,
  output logic              tx_ready,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              cs_n,
  output logic              sclk,
  input  logic [3:0]        io_in,
  output logic [3:0]        io_out,
  output logic [3:0]        io_oe
);
  localparam int BEAT_W = $clog2(DATA_W);

  initial begin
    assert_width_ok: assert (DATA_W % 4 == 0 && DATA_W >= 4);
  end

  st_e               st;
  lane_w_e           lw_q, lw_in;
  logic [LEN_W-1:0]  rd_q, byte_left;
  logic [BEAT_W-1:0] beat_left;
  logic              load, shift, drive;
  logic [3:0]        fill;
  logic [DATA_W-1:0] sh;

  function automatic logic [BEAT_W-1:0] last_beat(lane_w_e w);
    case (w)
      LW_FOUR: return BEAT_W'(DATA_W / 4 - 1);
      LW_TWO:  return BEAT_W'(DATA_W / 2 - 1);
      default: return BEAT_W'(DATA_W - 1);
    endcase
  endfunction

  always_comb begin
    case (lane_sel)
      2'd1:    lw_in = LW_TWO;
      2'd2:    lw_in = LW_FOUR;
      default: lw_in = LW_ONE;
    endcase
  end

  assign load     = (st == ST_LOAD) && tx_valid;
  assign shift    = (st == ST_RLO) || (st == ST_WHI && beat_left != '0);
  assign drive    = (st == ST_LOAD) || (st == ST_WLO) || (st == ST_WHI);
  assign sclk     = (st == ST_WHI) || (st == ST_THI) || (st == ST_RHI);
  assign cs_n     = (st == ST_IDLE);
  assign busy     = (st != ST_IDLE);
  assign tx_ready = (st == ST_LOAD);
  assign rx_data  = sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= ST_IDLE;
      lw_q      <= LW_ONE;
      rd_q      <= '0;
      byte_left <= '0;
      beat_left <= '0;
      rx_valid  <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      case (st)
        ST_IDLE: if (start && (wr_len != '0 || rd_len != '0)) begin
          lw_q <= lw_in;
          rd_q <= rd_len;
          if (wr_len != '0) begin
            byte_left <= wr_len;
            st        <= ST_LOAD;
          end else begin
            byte_left <= rd_len;
            beat_left <= last_beat(lw_in);
            st        <= ST_RLO;
          end
        end
        ST_LOAD: if (tx_valid) begin
          beat_left <= last_beat(lw_q);
          st        <= ST_WLO;
        end
        ST_WLO: st <= ST_WHI;
        ST_WHI: begin
          if (beat_left != '0) begin
            beat_left <= beat_left - 1'b1;
            st        <= ST_WLO;
          end else if (byte_left != LEN_W'(1)) begin
            byte_left <= byte_left - 1'b1;
            st        <= ST_LOAD;
          end else if (rd_q != '0) begin
            byte_left <= rd_q;
            st        <= ST_TLO;
          end else begin
            st <= ST_END;
          end
        end
        ST_TLO: st <= ST_THI;
        ST_THI: begin
          beat_left <= last_beat(lw_q);
          st        <= ST_RLO;
        end
        ST_RLO: begin
          rx_valid <= (beat_left == '0);
          st       <= ST_RHI;
        end
        ST_RHI: begin
          if (beat_left != '0) begin
            beat_left <= beat_left - 1'b1;
            st        <= ST_RLO;
          end else if (byte_left != LEN_W'(1)) begin
            byte_left <= byte_left - 1'b1;
            beat_left <= last_beat(lw_q);
            st        <= ST_RLO;
          end else begin
            st <= ST_END;
          end
        end
        ST_END:  st <= ST_IDLE;
        default: st <= ST_IDLE;
      endcase
    end
  end

  qsl_lane_map #(.DATA_W(DATA_W)) u_map (
    .lw(lw_q), .drive(drive), .sh(sh), .io_in(io_in),
    .io_out(io_out), .io_oe(io_oe), .fill(fill)
  );

  qsl_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(load), .load_val(tx_data),
    .shift(shift), .lw(lw_q), .fill(fill), .sh(sh)
  );

  // R1: an idle link drives nothing and keeps the clock low
  assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |-> (io_oe == 4'b0000 && !sclk && !rx_valid));
  // R2: lane values never move while the clock is high
  assert_out_stable_high_R2: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> ($stable(io_out) && $stable(io_oe)));
  // R7: a received byte never coincides with driven lanes
  assert_no_drive_on_read_R7: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |-> (io_oe == 4'b0000));
  // R9: waiting for a send byte holds the clock low
  assert_ready_clock_low_R9: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !sclk);
  // R12: every clock pulse sits inside the select window
  assert_select_covers_R12: assert property (@(posedge clk) disable iff (!rst_n)
    sclk |-> !cs_n);
endmodule

// File: tb/sim_qspi_lane_engine.sv
module sim_qspi_lane_engine;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       start = 1'b0;
  logic [1:0] lane_sel = 2'd0;
  logic [7:0] wr_len = '0, rd_len = '0;
  logic       busy;
  logic [7:0] tx_data = '0;
  logic       tx_valid = 1'b0;
  logic       tx_ready;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic       cs_n, sclk;
  logic [3:0] io_in = 4'h0;
  logic [3:0] io_out, io_oe;

  always #10 clk = ~clk;

  qspi_lane_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .lane_sel(lane_sel),
    .wr_len(wr_len), .rd_len(rd_len), .busy(busy),
    .tx_data(tx_data), .tx_valid(tx_valid), .tx_ready(tx_ready),
    .rx_data(rx_data), .rx_valid(rx_valid), .cs_n(cs_n), .sclk(sclk),
    .io_in(io_in), .io_out(io_out), .io_oe(io_oe)
  );

  int total = 0, bad = 0;
  int W = 1, nwr = 0, nrd = 0, stall_n = 0;
  int edges = 0, txk = 0, rxk = 0, stall_cnt = 0;
  bit active = 1'b0;
  logic sclk_q = 1'b0;
  logic [3:0] last_low = 4'h0;
  logic [7:0] txb [8];
  logic [7:0] rxb [8];

  task automatic chk(bit ok, string req, int act, int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  function automatic int grp_of(logic [7:0] b, int w, int beat);
    return (int'(b) >> (8 - w * (beat + 1))) & ((1 << w) - 1);
  endfunction

  always @(negedge clk) begin : mon
    int bpb, wb, rb, turn, k, b, e, ridx, g;
    string lreq;
    if (active) begin
      bpb  = 8 / W;
      wb   = nwr * bpb;
      rb   = nrd * bpb;
      turn = (nwr > 0 && nrd > 0) ? 1 : 0;
      lreq = (W == 4) ? "R3 quad lanes" : (W == 2) ? "R4 dual lanes" : "R5 single lane";
      if (sclk && !sclk_q) begin
        chk(cs_n == 1'b0, "R12 select low at edge", cs_n, 0);
        chk(io_out == last_low, "R2 out changed at rise", io_out, last_low);
        if (edges < wb) begin
          k = edges / bpb; b = edges % bpb;
          e = grp_of(txb[k], W, b);
          chk(int'(io_out) == e, lreq, io_out, e);
          chk(int'(io_oe) == (1 << W) - 1, "R7 write enables", io_oe, (1 << W) - 1);
        end else begin
          chk(io_oe == 4'h0, (edges < wb + turn) ? "R8 turnaround off" : "R7 read released", io_oe, 0);
        end
        edges++;
      end
      if (!sclk) last_low = io_out;
      if (tx_valid) begin
        tx_valid = 1'b0;
        txk++;
        stall_cnt = 0;
      end else if (tx_ready) begin
        chk(sclk == 1'b0, "R9 clock held while waiting", sclk, 0);
        if (stall_cnt >= stall_n && txk < 8) begin
          tx_valid = 1'b1;
          tx_data  = txb[txk];
        end else begin
          stall_cnt++;
        end
      end
      if (rx_valid) begin
        e = (rxk < 8) ? int'(rxb[rxk]) : -1;
        chk(int'(rx_data) == e, {"R10 ", lreq}, rx_data, e);
        rxk++;
      end
      if (!sclk) begin
        ridx = edges - wb - turn;
        if (ridx >= 0 && ridx < rb) begin
          k = ridx / bpb; b = ridx % bpb;
          g = grp_of(rxb[k], W, b);
          if (W == 1)      io_in = {2'b11, g[0], 1'b1};
          else if (W == 2) io_in = {2'b11, g[1:0]};
          else             io_in = g[3:0];
        end else begin
          io_in = 4'hA;
        end
      end
    end
    sclk_q = sclk;
  end

  task automatic run(int code, int w_n, int r_n, int st_n, bit poke, int seed);
    int guard, turn;
    W = (code == 2) ? 4 : (code == 1) ? 2 : 1;
    nwr = w_n; nrd = r_n; stall_n = st_n;
    for (int i = 0; i < 8; i++) begin
      txb[i] = 8'((seed * 37 + i * 91 + 5) & 255);
      rxb[i] = 8'((seed * 53 + i * 29 + 163) & 255);
    end
    edges = 0; txk = 0; rxk = 0; stall_cnt = 0;
    @(negedge clk);
    active = 1'b1;
    start = 1'b1; lane_sel = 2'(code); wr_len = 8'(w_n); rd_len = 8'(r_n);
    @(negedge clk);
    start = 1'b0;
    chk(cs_n == 1'b0 && busy, "R12 select after start", cs_n, 0);
    if (poke) begin
      @(negedge clk);
      start = 1'b1; lane_sel = 2'd2; wr_len = 8'd5; rd_len = 8'd5;
      @(negedge clk);
      start = 1'b0;
    end
    guard = 0;
    while (busy && guard < 5000) begin
      @(negedge clk);
      guard++;
    end
    active = 1'b0;
    turn = (w_n > 0 && r_n > 0) ? 1 : 0;
    chk(edges == (w_n + r_n) * (8 / W) + turn, "R6 edge total", edges, (w_n + r_n) * (8 / W) + turn);
    chk(txk == w_n, "R11 bytes sent", txk, w_n);
    chk(rxk == r_n, "R11 bytes received", rxk, r_n);
    chk(cs_n && !sclk && io_oe == 4'h0 && !tx_ready, "R1 idle after transaction", {cs_n, sclk, io_oe}, 8'h20);
    repeat (2) @(negedge clk);
  endtask

  initial begin : main
    int seed;
    seed = 1;
    repeat (3) @(negedge clk);
    chk(cs_n && !sclk && io_oe == 0 && !busy && !tx_ready && !rx_valid,
        "R1 reset state", {cs_n, sclk, busy, tx_ready, rx_valid}, 16);
    rst_n = 1'b1;
    @(negedge clk);
    for (int code = 0; code < 3; code++) begin
      for (int cfg = 0; cfg < 4; cfg++) begin
        for (int st = 0; st < 3; st += 2) begin
          case (cfg)
            0: run(code, 1, 0, st, 1'b0, seed);
            1: run(code, 0, 1, st, 1'b0, seed);
            2: run(code, 2, 3, st, 1'b1, seed);
            default: run(code, 3, 2, st, 1'b0, seed);
          endcase
          seed++;
        end
      end
    end
    run(3, 2, 2, 1, 1'b0, seed);
    @(negedge clk);
    start = 1'b1; lane_sel = 2'd2; wr_len = 8'd0; rd_len = 8'd0;
    @(negedge clk);
    start = 1'b0;
    for (int i = 0; i < 6; i++) begin
      chk(cs_n && !busy && !sclk, "R11 empty start ignored", {cs_n, busy, sclk}, 4);
      @(negedge clk);
    end
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL R11 watchdog act=hung exp=done");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule